// File: doc/BRIEF.md
# Serial memory write-protection controller

This block is the protection core of a small serial memory with a 2K-byte array. An upstream deserializer hands it one decoded instruction per cycle. The instruction can be an array write with its 11-bit address, a status register write with new protection settings, or one of the commands that set or clear the write enable latch or the user flag. The block also watches the level of the active-low write-protect pin. For every write request it answers grant or deny. It keeps the protection state and shows it as a status byte that the read path returns.

Four bits control protection. The volatile write enable latch must be set before any write. Two non-volatile range bits lock the top quarter, the top half or the whole array. Protected locations stay readable. A non-volatile pin-lock enable bit, when set, lets a low write-protect pin freeze the status register. A granted write starts a fixed-length busy window. The new settings of a status write take effect when that window ends, so a protect pin that drops in the middle does not abort a write that has already started. A soft reset clears the volatile bits and leaves the non-volatile bits as they are.

Top module: `sermem_protect`

## Requirements
- R1: After power reset (`rst_n` low, then two clock cycles after release) `status` is 0x00 and `grant`, `deny` and `busy` are 0. Status layout: bit0 busy, bit1 write enable latch, bits 3:2 range bits, bit4 flag, bit7 pin-lock enable, bits 6:5 zero.
- R2: `cmd_op` 1 sets the write enable latch and `cmd_op` 2 clears it. The new value is visible on `status` bit1 one cycle after the command, and both commands are ignored while busy.
- R3: An array write (`cmd_op` 6) is granted only when the latch is 1, busy is 0 and the address lies outside the protected range. Otherwise it is denied.
- R4: Protected range by range bits (`status` bits 3:2): 00 none, 01 addresses 0x600–0x7FF, 10 addresses 0x400–0x7FF, 11 the whole array.
- R5: A status write (`cmd_op` 3) is granted only when the latch is 1 and busy is 0. It is also refused when the pin-lock enable bit is 1 and `wp_n` is 0. When that bit is 0, `wp_n` has no effect.
- R6: Each grant raises `busy` (and `status` bit0) for exactly BUSY_CYCLES cycles, starting in the cycle in which `grant` is seen.
- R7: Any write request made while busy is denied and changes no state.
- R8: When the busy window ends, the latch clears. A granted status write then loads `cmd_bl` into the range bits and `cmd_lock` into the pin-lock enable bit, both captured at the request. These bits change at no other time.
- R9: A change of `wp_n` during the busy window of a granted status write does not stop that write from taking effect.
- R10: `cmd_op` 4 sets the flag (`status` bit4) and `cmd_op` 5 clears it, also while busy.
- R11: `soft_rst` clears the latch and the flag, and commands in the same cycle are ignored. It keeps the range and pin-lock bits and does not cut short a busy window.
- R12: Each write request gets exactly one of `grant` or `deny`, one cycle later. Other codes (0 and 7) give neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power reset |
| soft_rst | input | 1 | Synchronous soft reset of the volatile bits |
| cmd_valid | input | 1 | Decoded instruction present this cycle |
| cmd_op | input | 3 | Instruction code |
| cmd_addr | input | ADDR_W | Array address of a write request |
| cmd_bl | input | 2 | New range bits carried by a status write |
| cmd_lock | input | 1 | New pin-lock enable carried by a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| grant | output | 1 | Write request accepted (one cycle pulse) |
| deny | output | 1 | Write request refused (one cycle pulse) |
| busy | output | 1 | Non-volatile write cycle in progress |
| status | output | 8 | Status byte for reads |

## Verification
Directed sequences step through each range setting. Each one probes the first protected and the last unprotected address, which separates an off-by-one boundary from a wrong range. Status writes are tried with the pin high, with the pin low and the lock bit set, and with the pin low and the lock bit clear, which isolates the pin gate from the latch gate. The pin is dropped during a running status write to show that the commit survives. Soft reset is issued in the middle of such a write. A long random stream then mixes every code, random addresses, protect-pin levels and soft resets, so requests often arrive while busy or with the latch clear. A cycle model compares every cycle.

// File: rtl/sermem_pkg.sv
`timescale 1ns/1ps
package sermem_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_WEL_SET  = 3'd1,
    OP_WEL_CLR  = 3'd2,
    OP_STAT_WR  = 3'd3,
    OP_FLAG_SET = 3'd4,
    OP_FLAG_CLR = 3'd5,
    OP_ARR_WR   = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  localparam int ST_BUSY  = 0;
  localparam int ST_WEL   = 1;
  localparam int ST_BL_LO = 2;
  localparam int ST_BL_HI = 3;
  localparam int ST_FLAG  = 4;
  localparam int ST_LOCK  = 7;
endpackage

// File: rtl/sermem_rst_sync.sv
`timescale 1ns/1ps
module sermem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/sermem_lock_range.sv
`timescale 1ns/1ps
module sermem_lock_range #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bl,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam logic [ADDR_W-1:0] BASE_QTR  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] BASE_HALF = {2'b10, {(ADDR_W-2){1'b0}}};

  logic [ADDR_W-1:0] base;

  always_comb begin
    case (bl)
      2'b01:   base = BASE_QTR;
      2'b10:   base = BASE_HALF;
      default: base = '0;
    endcase
    locked = (bl != 2'b00) && (addr >= base);
  end
endmodule

// File: rtl/sermem_nv_timer.sv
`timescale 1ns/1ps
module sermem_nv_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start)             cnt_d = LOAD;
    else if (cnt_q != '0)  cnt_d = cnt_q - ONE;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);
endmodule

// File: rtl/sermem_protect.sv
`timescale 1ns/1ps
module sermem_protect
  import sermem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_bl,
  input  logic              cmd_lock,
  input  logic              wp_n,
  output logic              grant,
  output logic              deny,
  output logic              busy,
  output logic [7:0]        status
);
  logic rst_q_n;
  op_e  op;
  logic accept, wr_arr, wr_st, addr_locked, pin_lock;
  logic arr_ok, st_ok, grant_d, deny_d, done;
  logic wel_q, wel_d, flag_q, flag_d, lock_q, lock_d;
  logic [1:0] bl_q, bl_d;
  logic pend_st_q, pend_lock_q;
  logic [1:0] pend_bl_q;
  logic grant_q, deny_q;

  sermem_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_q_n(rst_q_n)
  );

  sermem_lock_range #(.ADDR_W(ADDR_W)) u_range (
    .bl(bl_q), .addr(cmd_addr), .locked(addr_locked)
  );

  sermem_nv_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_q_n), .start(grant_d), .busy(busy), .done(done)
  );

  // request decode and grant decision
  always_comb begin
    op       = op_e'(cmd_op);
    accept   = cmd_valid && !soft_rst;
    wr_arr   = accept && (op == OP_ARR_WR);
    wr_st    = accept && (op == OP_STAT_WR);
    pin_lock = lock_q && !wp_n;
    arr_ok   = !busy && wel_q && !addr_locked;
    st_ok    = !busy && wel_q && !pin_lock;
    grant_d  = (wr_arr && arr_ok) || (wr_st && st_ok);
    deny_d   = (wr_arr || wr_st) && !grant_d;
  end

  // next state of the protection bits
  always_comb begin
    wel_d = wel_q;
    if (soft_rst)                          wel_d = 1'b0;
    else if (done)                         wel_d = 1'b0;
    else if (cmd_valid && !busy) begin
      if (op == OP_WEL_SET)                wel_d = 1'b1;
      else if (op == OP_WEL_CLR)           wel_d = 1'b0;
    end

    flag_d = flag_q;
    if (soft_rst)                          flag_d = 1'b0;
    else if (cmd_valid && op == OP_FLAG_SET) flag_d = 1'b1;
    else if (cmd_valid && op == OP_FLAG_CLR) flag_d = 1'b0;

    bl_d   = bl_q;
    lock_d = lock_q;
    if (done && pend_st_q) begin
      bl_d   = pend_bl_q;
      lock_d = pend_lock_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wel_q   <= 1'b0;
      flag_q  <= 1'b0;
      bl_q    <= 2'b00;
      lock_q  <= 1'b0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      wel_q   <= wel_d;
      flag_q  <= flag_d;
      bl_q    <= bl_d;
      lock_q  <= lock_d;
      grant_q <= grant_d;
      deny_q  <= deny_d;
    end
  end

  // pending write captured at grant, enabled by the grant only
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pend_st_q   <= 1'b0;
      pend_bl_q   <= 2'b00;
      pend_lock_q <= 1'b0;
    end else if (grant_d) begin
      pend_st_q   <= wr_st;
      pend_bl_q   <= cmd_bl;
      pend_lock_q <= cmd_lock;
    end
  end

  always_comb begin
    status           = 8'h00;
    status[ST_BUSY]  = busy;
    status[ST_WEL]   = wel_q;
    status[ST_BL_LO] = bl_q[0];
    status[ST_BL_HI] = bl_q[1];
    status[ST_FLAG]  = flag_q;
    status[ST_LOCK]  = lock_q;
  end

  assign grant = grant_q;
  assign deny  = deny_q;
endmodule

// File: rtl/sermem_protect_chk.sv
`timescale 1ns/1ps
module sermem_protect_chk
  import sermem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       wp_n,
  input logic       grant,
  input logic       deny,
  input logic       busy,
  input logic       stat_busy,
  input logic       wel,
  input logic       flag,
  input logic [1:0] bl,
  input logic       lock_en
);
  logic is_wr;
  assign is_wr = cmd_valid && !soft_rst &&
                 (cmd_op == OP_ARR_WR || cmd_op == OP_STAT_WR);

  a_r12_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  a_r12_response_source: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> $past(is_wr));

  a_r6_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (busy && stat_busy));

  a_r7_busy_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_wr) |=> deny);

  a_r3_latch_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !soft_rst && cmd_op == OP_ARR_WR && !wel) |=> deny);

  a_r5_pin_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !soft_rst && cmd_op == OP_STAT_WR && lock_en && !wp_n) |=> deny);

  a_r8_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(bl) && $stable(lock_en)));

  a_r8_latch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!wel && !flag));
endmodule

bind sermem_protect sermem_protect_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .wp_n(wp_n), .grant(grant), .deny(deny), .busy(busy),
  .stat_busy(status[0]), .wel(status[1]), .flag(status[4]),
  .bl(status[3:2]), .lock_en(status[7])
);

// File: tb/sermem_protect_bench.sv
`timescale 1ns/1ps
module sermem_protect_bench;
  import sermem_pkg::*;
  localparam int ADDR_W = 11;
  localparam int BUSY   = 16;

  logic clk, rst_n, soft_rst, cmd_valid, cmd_lock, wp_n;
  logic [2:0] cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [1:0] cmd_bl;
  logic grant, deny, busy;
  logic [7:0] status;

  int checks = 0, fails = 0;
  bit m_wel, m_flag, m_lock, m_pst, m_plock, e_grant, e_deny;
  bit [1:0] m_bl, m_pbl;
  int m_cnt;
  bit cur_wp = 1'b1;

  sermem_protect #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY)) u_sermem_protect (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_bl(cmd_bl), .cmd_lock(cmd_lock),
    .wp_n(wp_n), .grant(grant), .deny(deny), .busy(busy), .status(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit locked_f(bit [1:0] bl, logic [ADDR_W-1:0] a);
    case (bl)
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_lock, 2'b00, m_flag, m_bl, m_wel, (m_cnt != 0)};
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (grant !== e_grant || deny !== e_deny || busy !== (m_cnt != 0) ||
        status !== exp_status()) begin
      fails++;
      $display("FAIL %s: got grant=%0b deny=%0b busy=%0b status=%02h, expected grant=%0b deny=%0b busy=%0b status=%02h",
               tag, grant, deny, busy, status, e_grant, e_deny, (m_cnt != 0), exp_status());
    end
  endtask

  task automatic step(input bit v, input op_e op, input logic [ADDR_W-1:0] a,
                      input bit [1:0] bl, input bit lk, input bit wp, input bit sr,
                      input string tag);
    bit is_wr, ok;
    int prev;
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_bl = bl; cmd_lock = lk;
    wp_n = wp; soft_rst = sr;
    @(posedge clk);
    is_wr = v && !sr && (op == OP_ARR_WR || op == OP_STAT_WR);
    ok = 1'b0;
    if (is_wr && m_cnt == 0) begin
      if (op == OP_ARR_WR) ok = m_wel && !locked_f(m_bl, a);
      else                 ok = m_wel && !(m_lock && !wp);
    end
    e_grant = is_wr && ok;
    e_deny  = is_wr && !ok;
    prev = m_cnt;
    if (prev == 1) begin
      m_wel = 1'b0;
      if (m_pst) begin m_bl = m_pbl; m_lock = m_plock; end
    end
    if (prev != 0) m_cnt--;
    if (e_grant) begin
      m_cnt = BUSY; m_pst = (op == OP_STAT_WR); m_pbl = bl; m_plock = lk;
    end
    if (v && !sr && prev == 0) begin
      if (op == OP_WEL_SET) m_wel = 1'b1;
      if (op == OP_WEL_CLR) m_wel = 1'b0;
    end
    if (v && !sr) begin
      if (op == OP_FLAG_SET) m_flag = 1'b1;
      if (op == OP_FLAG_CLR) m_flag = 1'b0;
    end
    if (sr) begin m_wel = 1'b0; m_flag = 1'b0; end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cmd(input op_e op, input logic [ADDR_W-1:0] a, input bit [1:0] bl,
                     input bit lk, input string tag);
    step(1'b1, op, a, bl, lk, cur_wp, 1'b0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, OP_NOP, '0, 2'b00, 1'b0, cur_wp, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got no finish, expected finish before cycle limit");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; soft_rst = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    cmd_addr = '0; cmd_bl = 2'b00; cmd_lock = 1'b0; wp_n = 1'b1;
    m_wel = 0; m_flag = 0; m_lock = 0; m_bl = 0; m_cnt = 0; m_pst = 0;
    m_pbl = 0; m_plock = 0; e_grant = 0; e_deny = 0;
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 after reset");

    cmd(OP_ARR_WR, 11'h100, 2'b00, 1'b0, "R3 latch clear denies");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2 set latch");
    cmd(OP_WEL_CLR, '0, 2'b00, 1'b0, "R2 clear latch");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2 set latch again");
    cmd(OP_ARR_WR, 11'h7FF, 2'b00, 1'b0, "R3 unprotected write granted");
    cmd(OP_ARR_WR, 11'h000, 2'b00, 1'b0, "R7 request while busy");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2 set ignored while busy");
    idle(BUSY, "R6 busy window, R8 latch clears");

    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b01, 1'b0, "R5 status write granted");
    idle(BUSY, "R8 range bits load at end");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_ARR_WR, 11'h600, 2'b00, 1'b0, "R4 quarter lower bound locked");
    cmd(OP_ARR_WR, 11'h5FF, 2'b00, 1'b0, "R4 below quarter open");
    idle(BUSY, "R6");

    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b10, 1'b0, "R5");
    idle(BUSY, "R8");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_ARR_WR, 11'h400, 2'b00, 1'b0, "R4 half lower bound locked");
    cmd(OP_ARR_WR, 11'h3FF, 2'b00, 1'b0, "R4 below half open");
    idle(BUSY, "R6");

    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b11, 1'b0, "R5");
    idle(BUSY, "R8");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_ARR_WR, 11'h000, 2'b00, 1'b0, "R4 whole array locked");

    cmd(OP_STAT_WR, '0, 2'b00, 1'b1, "R5 lock bit set with pin high");
    idle(BUSY, "R8");
    cur_wp = 1'b0;
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b11, 1'b0, "R5 pin low with lock refused");
    cur_wp = 1'b1;
    cmd(OP_STAT_WR, '0, 2'b11, 1'b0, "R5 pin high granted");
    cur_wp = 1'b0;
    idle(BUSY, "R9 pin drop during write");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b00, 1'b0, "R5 lock clear ignores pin");
    idle(BUSY, "R8");

    cmd(OP_FLAG_SET, '0, 2'b00, 1'b0, "R10 flag set");
    cmd(OP_FLAG_CLR, '0, 2'b00, 1'b0, "R10 flag clear");
    cmd(OP_FLAG_SET, '0, 2'b00, 1'b0, "R10 flag set again");

    cur_wp = 1'b1;
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_STAT_WR, '0, 2'b10, 1'b1, "R5");
    step(1'b1, OP_FLAG_SET, '0, 2'b00, 1'b0, cur_wp, 1'b1, "R11 soft reset mid write");
    idle(BUSY, "R11 write still completes");
    cmd(OP_WEL_SET, '0, 2'b00, 1'b0, "R2");
    cmd(OP_FLAG_SET, '0, 2'b00, 1'b0, "R10");
    step(1'b0, OP_NOP, '0, 2'b00, 1'b0, cur_wp, 1'b1, "R11 soft reset keeps range and lock");
    cmd(OP_RSVD, 11'h123, 2'b11, 1'b1, "R12 reserved code no response");
    cmd(OP_NOP, 11'h123, 2'b11, 1'b1, "R12 no-op no response");

    for (int i = 0; i < 3000; i++) begin
      int r;
      op_e op;
      bit v;
      v = 1'b1;
      r = $urandom_range(0, 15);
      case (r)
        0, 1, 2, 3: op = OP_WEL_SET;
        4, 5, 6:    op = OP_ARR_WR;
        7, 8:       op = OP_STAT_WR;
        9:          op = OP_WEL_CLR;
        10:         op = OP_FLAG_SET;
        11:         op = OP_FLAG_CLR;
        12:         op = OP_NOP;
        13:         op = OP_RSVD;
        default: begin op = OP_NOP; v = 1'b0; end
      endcase
      if ($urandom_range(0, 4) == 0) cur_wp = 1'($urandom_range(0, 1));
      step(v, op, ADDR_W'($urandom_range(0, 2047)), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), cur_wp, ($urandom_range(0, 49) == 0),
           "R3 R4 R5 R7 R12 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule